// File: doc/BRIEF.md
# Partially Decoded Memory Map Controller

This block is the memory front end of a small 8-bit home computer with a 16-bit address bus. To keep the decoder small it looks at only one upper address line, A14. A low A14 selects the internal ROM and a high A14 selects the internal RAM. Every other upper line is left undecoded, so both devices appear several times in the 64 KB map. The internal RAM is a 1 KB byte array addressed by A9..A0 alone. Any access with A14 set lands somewhere in that kilobyte, including the whole 0xC000 upper quarter.

An expansion port lets an attached RAM pack take the bus away from the internal devices. A two-bit mode input selects how the pack behaves:

- It can keep the internal RAM permanently deselected.
- It can occupy the ROM's upper mirror at 0x8000–0xBFFF and deselect the ROM there.
- It can deselect the internal RAM only above its lowest kilobyte mirror.

The controller asserts the external select wherever the pack responds. No two selects are ever active together.

Top module: `memmap_ctrl`

## Requirements
- R1: With mode 2'b00 (no pack) and `mreq_n` low, `rom_cs_n` is low when A14=0 and `ram_cs_n` is low when A14=1; `ext_cs_n` stays high.
- R2: While `mreq_n` is high, `rom_cs_n`, `ram_cs_n` and `ext_cs_n` are all high, whatever the address or mode.
- R3: Internal RAM uses only A9..A0. 0x4000, 0x4400, 0x7C00 and 0xC000 all reach byte 0, because A10..A13 and A15 are ignored.
- R4: A15 takes no part in ROM decoding. Outside remap mode, addresses from 0x8000 to 0xBFFF select the ROM exactly as 0x0000 to 0x3FFF do.
- R5: A byte is stored on the rising clock edge when `wr_n` is low and the internal RAM select is active. A write while the ROM select is active, or while the internal RAM select is inactive, changes no RAM byte.
- R6: `rdata` shows the stored byte at A9..A0 without a clock delay when the internal RAM select is active and `rd_n` is low. In every other case it reads 8'h00.
- R7: Mode 2'b01 (pack always overrides) keeps `ram_cs_n` high for every address. `ext_cs_n` goes low on each memory request with A14=1.
- R8: Mode 2'b10 (remap) applies in the window where A15=1 and A14=0. There `rom_cs_n` is forced high and `ext_cs_n` is low during a memory request. Outside the window, decoding is as in R1.
- R9: Mode 2'b11 (selective) applies to memory requests with A14=1. If any of A13..A10 is 1, `ram_cs_n` is high and `ext_cs_n` is low. If A13..A10 are all 0, the internal RAM is selected.
- R10: At most one of `rom_cs_n`, `ram_cs_n` and `ext_cs_n` is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for RAM writes |
| rst_n | input | 1 | Active-low reset; blocks RAM writes while low |
| addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Write data from CPU |
| pack_mode | input | 2 | Expansion pack behaviour: 00 none, 01 always, 10 remap, 11 selective |
| rdata | output | 8 | Read data from internal RAM |
| rom_cs_n | output | 1 | Active-low internal ROM select |
| ram_cs_n | output | 1 | Active-low internal RAM select |
| ext_cs_n | output | 1 | Active-low expansion pack select |

## Verification
Assertions check four things on every cycle:
- The three selects stay mutually exclusive.
- No select is active without a memory request.
- The override and remap modes keep the internal RAM or ROM deselected.
- A qualified write leaves its byte in the array one cycle later.

Only the bench's scenarios can show the aliasing behaviour. This covers a byte written through one mirror and read back through another, writes into the ROM region or into overridden RAM leaving stored data unchanged, and read data appearing with no clock delay. The bench checks these with directed mirror cases, then a seeded random mix of modes, addresses and strobes.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    PACK_NONE   = 2'b00,
    PACK_ALWAYS = 2'b01,
    PACK_REMAP  = 2'b10,
    PACK_SELECT = 2'b11
  } pack_mode_e;

  // True when the CPU address falls in the pack's relocated window (A15=1, A14=0)
  function automatic logic in_remap_window(input logic [15:0] a);
    return a[15] & ~a[14];
  endfunction

  // True when any undecoded line between the RAM index and A14 is set
  function automatic logic above_base_mirror(input logic [15:0] a, input int aw);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < 14; i++) begin
      if (i >= aw) hit = hit | a[i];
    end
    return hit;
  endfunction

endpackage

// File: rtl/memmap_decode.sv
module memmap_decode
  import memmap_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      addr,
  input  logic             mreq_n,
  input  pack_mode_e       mode,
  output logic             rom_sel,
  output logic             ram_sel,
  output logic             ext_sel
);

  logic req;
  logic a14;
  logic remap_win;
  logic upper_hit;
  logic rom_base;
  logic ram_base;
  logic rom_block;
  logic ram_block;

  assign req       = ~mreq_n;
  assign a14       = addr[14];
  assign remap_win = in_remap_window(addr);
  assign upper_hit = above_base_mirror(addr, RAM_AW);
  assign rom_base  = req & ~a14;
  assign ram_base  = req & a14;

  always_comb begin
    rom_block = 1'b0;
    ram_block = 1'b0;
    ext_sel   = 1'b0;
    unique case (mode)
      PACK_NONE: ;
      PACK_ALWAYS: begin
        ram_block = 1'b1;
        ext_sel   = ram_base;
      end
      PACK_REMAP: begin
        rom_block = remap_win;
        ext_sel   = req & remap_win;
      end
      PACK_SELECT: begin
        ram_block = upper_hit;
        ext_sel   = ram_base & upper_hit;
      end
      default: ;
    endcase
  end

  assign rom_sel = rom_base & ~rom_block;
  assign ram_sel = ram_base & ~ram_block;

  p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_sel, ram_sel, ext_sel}) <= 1);

  p_idle_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> !(rom_sel || ram_sel || ext_sel));

  p_always_blocks_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PACK_ALWAYS) |-> !ram_sel);

  p_remap_blocks_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PACK_REMAP && addr[15] && !addr[14]) |-> !rom_sel);

  p_select_keeps_low_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PACK_SELECT && !mreq_n && addr[14] && addr[13:RAM_AW] == '0) |-> ram_sel);

endmodule

// File: rtl/memmap_ram.sv
module memmap_ram #(
  parameter int RAM_AW = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [RAM_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem [DEPTH];
  logic          we;
  logic          re;

  assign we = rst_n & sel & ~wr_n;
  assign re = sel & ~rd_n;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = re ? mem[idx] : '0;

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(idx)] == $past(wdata)));

  p_quiet_when_unselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (rdata == '0));

endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   addr,
  input  logic          mreq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    pack_mode,
  output logic [DW-1:0] rdata,
  output logic          rom_cs_n,
  output logic          ram_cs_n,
  output logic          ext_cs_n
);

  pack_mode_e mode;
  logic       rom_sel;
  logic       ram_sel;
  logic       ext_sel;

  assign mode = pack_mode_e'(pack_mode);

  memmap_decode #(.RAM_AW(RAM_AW)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .mreq_n  (mreq_n),
    .mode    (mode),
    .rom_sel (rom_sel),
    .ram_sel (ram_sel),
    .ext_sel (ext_sel)
  );

  memmap_ram #(.RAM_AW(RAM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (ram_sel),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .idx   (addr[RAM_AW-1:0]),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign rom_cs_n = ~rom_sel;
  assign ram_cs_n = ~ram_sel;
  assign ext_cs_n = ~ext_sel;

  p_rom_low_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && pack_mode == 2'b00 && !addr[14]) |-> (!rom_cs_n && ext_cs_n));

endmodule

// File: tb/memmap_ctrl_tb.sv
module memmap_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mreq_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  wdata = '0;
  logic [1:0]  pack_mode = 2'b00;
  logic [7:0]  rdata;
  logic        rom_cs_n, ram_cs_n, ext_cs_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .wdata(wdata), .pack_mode(pack_mode), .rdata(rdata),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ext_cs_n(ext_cs_n)
  );

  // Expected selects, active-high, as {rom, ram, ext}
  function automatic logic [2:0] want_sel(logic [15:0] a, logic [1:0] m, logic rq_n);
    logic rom, ram, ext;
    logic win, hi;
    rom = 0; ram = 0; ext = 0;
    win = (a[15:14] == 2'b10);
    hi  = (a[13:10] != 4'h0);
    if (!rq_n) begin
      if (a[14]) begin
        case (m)
          2'b01: ext = 1;
          2'b11: begin ext = hi; ram = !hi; end
          default: ram = 1;
        endcase
      end else begin
        if (m == 2'b10 && win) ext = 1;
        else rom = 1;
      end
    end
    return {rom, ram, ext};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, compare, then commit the model write
  task automatic cycle(string req, logic [15:0] a, logic [1:0] m, logic rq_n,
                       logic r_n, logic w_n, logic [7:0] d);
    logic [2:0] s;
    logic [7:0] er;
    @(negedge clk);
    addr = a; pack_mode = m; mreq_n = rq_n; rd_n = r_n; wr_n = w_n; wdata = d;
    #1;
    s  = want_sel(a, m, rq_n);
    er = (s[1] && !r_n) ? model[a[9:0]] : 8'h00;
    check(req, {29'd0, ~rom_cs_n, ~ram_cs_n, ~ext_cs_n}, {29'd0, s});
    check(req, {24'd0, rdata}, {24'd0, er});
    if (s[1] && !w_n) model[a[9:0]] = d;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_81));
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state, no request
    check("R2 reset", {29'd0, rom_cs_n, ram_cs_n, ext_cs_n}, 32'd7);
    @(negedge clk); rst_n = 1'b1;

    // Fill the RAM through the base mirror (R1, R5)
    for (int i = 0; i < 1024; i++)
      cycle("R1/R5 fill", 16'h4000 + 16'(i), 2'b00, 0, 1, 0, 8'(i * 7 + 3));

    // R3: aliases of byte 0
    cycle("R5 write 4000", 16'h4000, 2'b00, 0, 1, 0, 8'hA5);
    cycle("R3 alias 4400", 16'h4400, 2'b00, 0, 0, 1, 8'h00);
    cycle("R3 alias 7C00", 16'h7C00, 2'b00, 0, 0, 1, 8'h00);
    cycle("R3 alias C000", 16'hC000, 2'b00, 0, 0, 1, 8'h00);
    check("R3 value", {24'd0, rdata}, 32'hA5);
    // R4: ROM mirror at 0x8000 and 0x0000
    cycle("R4 rom 8000", 16'h8000, 2'b00, 0, 0, 1, 8'h00);
    cycle("R4 rom 0123", 16'h0123, 2'b00, 0, 0, 1, 8'h00);
    // R5: write into ROM region ignored
    cycle("R5 set 4123", 16'h4123, 2'b00, 0, 1, 0, 8'h11);
    cycle("R5 rom write", 16'h0123, 2'b00, 0, 1, 0, 8'h99);
    cycle("R5 readback", 16'h4123, 2'b00, 0, 0, 1, 8'h00);
    check("R5 value", {24'd0, rdata}, 32'h11);
    // R7: always mode blocks RAM writes
    cycle("R7 write blocked", 16'h4000, 2'b01, 0, 1, 0, 8'h3C);
    cycle("R7 readback", 16'h4000, 2'b00, 0, 0, 1, 8'h00);
    check("R7 value", {24'd0, rdata}, 32'hA5);
    // R8: remap window and its edges
    cycle("R8 window low", 16'h8000, 2'b10, 0, 0, 1, 8'h00);
    cycle("R8 window high", 16'hBFFF, 2'b10, 0, 0, 1, 8'h00);
    cycle("R8 outside rom", 16'h3FFF, 2'b10, 0, 0, 1, 8'h00);
    cycle("R8 outside ram", 16'hC001, 2'b10, 0, 0, 1, 8'h00);
    // R9: selective mode
    cycle("R9 upper write", 16'h4400, 2'b11, 0, 1, 0, 8'h77);
    cycle("R9 base read", 16'h4000, 2'b11, 0, 0, 1, 8'h00);
    check("R9 value", {24'd0, rdata}, 32'hA5);
    cycle("R9 A13 set", 16'h6000, 2'b11, 0, 0, 1, 8'h00);
    // R2 and R6: no request, no select, no data
    cycle("R2 idle", 16'h4000, 2'b00, 1, 0, 1, 8'h00);
    cycle("R6 no strobe", 16'h4000, 2'b00, 0, 1, 1, 8'h00);

    // Random mix (R1..R10)
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [1:0] op;
      a  = 16'($urandom);
      op = 2'($urandom_range(0, 2));
      cycle("R10 random", a, 2'($urandom), ($urandom_range(0, 9) == 0),
            op != 0, op != 1, 8'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule